// File: doc/BRIEF.md
# I2C Status and Interrupt Flag Unit

This block holds the status word and the interrupt request of a byte-oriented I2C controller. A separate bus engine reports single-cycle event strobes (own address matched, general call address seen, byte finished, stop seen, arbitration lost, acknowledge bit sampled). It also drives level signals for the current role and direction and for a bus held by another master. The CPU sets two control bits: acknowledge enable and general call enable.

The unit combines these into an 8-bit read-only status word. It raises an interrupt request only for a fixed set of qualified events. That request is cleared as a side effect of the CPU reading the status word. A small data shift register sits beside it. The CPU loads a byte into it, and the bus engine shifts bits through it most significant bit first.

Top module: `i2c_stat_unit`

## Requirements
- R1: Reset clears every status bit and the data register, and holds `irq` and `irq_stop` at 0.
- R2: Status bit positions, from bit 7 down to bit 0: general call, stop, interrupt, transmit, bus busy, bus lost, NACK response, slave. Bits 4, 3 and 0 are registered copies of `is_tx`, `bus_busy` and `is_slave_sel`, one cycle after those inputs.
- R3: `ev_own_addr` with `ack_en`=1 sets the interrupt bit on the next cycle. With `ack_en`=0 the strobe has no effect.
- R4: `ev_gen_call` with both `gc_en`=1 and `ack_en`=1 sets the general call bit and the interrupt bit. If either enable is 0, the strobe has no effect.
- R5: `ev_byte_done` sets the interrupt bit when `is_master`=1 (also when `ev_arb_lost` arrives with it) or when `is_slave_sel`=1. With neither level high, the strobe has no effect.
- R6: `ev_stop` while `is_slave_sel`=1 sets the stop bit and the interrupt bit and marks the interrupt as stop-type. Otherwise the strobe has no effect.
- R7: `ev_ack_smp` loads the NACK bit from `ack_nack` (1 = NACK, 0 = ACK). `ev_arb_lost` sets the bus lost bit.
- R8: A `stat_rd` cycle clears the interrupt, general call, stop and bus lost bits on the next cycle. `stat_q` in the read cycle still shows the old value.
- R9: If `stat_rd` and an interrupt-setting event fall in the same cycle, the interrupt bit stays 1.
- R10: `irq` is a level equal to the interrupt bit. `irq_stop` is 1 only while a stop-type interrupt is pending and 0 for acknowledge-type interrupts.
- R11: `dat_wr` loads `dat_wdata`. `shift_en` shifts `dat_q` toward the MSB, with `shift_in` entering bit 0. `shift_out` is `dat_q[7]`. A load in the same cycle as a shift wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_own_addr | input | 1 | Own slave address received (strobe) |
| ev_gen_call | input | 1 | General call address received (strobe) |
| ev_byte_done | input | 1 | Data byte sent or received (strobe) |
| ev_stop | input | 1 | Stop condition seen (strobe) |
| ev_arb_lost | input | 1 | Arbitration lost (strobe) |
| ev_ack_smp | input | 1 | Acknowledge bit sampled (strobe) |
| ack_nack | input | 1 | Sampled acknowledge value, 1 = NACK |
| is_master | input | 1 | Engine acts as master (level) |
| is_slave_sel | input | 1 | Engine is the addressed slave (level) |
| is_tx | input | 1 | Engine is transmitting (level) |
| bus_busy | input | 1 | Another master holds the bus (level) |
| ack_en | input | 1 | Acknowledge enable control bit |
| gc_en | input | 1 | General call enable control bit |
| stat_rd | input | 1 | CPU read of the status word (strobe) |
| stat_q | output | 8 | Status word |
| irq | output | 1 | Interrupt request level |
| irq_stop | output | 1 | Pending interrupt is stop-type |
| dat_wr | input | 1 | Load the data register |
| dat_wdata | input | DW | Data to load |
| shift_en | input | 1 | Shift the data register one bit |
| shift_in | input | 1 | Bit entering at bit 0 |
| shift_out | output | 1 | Bit leaving at the MSB |
| dat_q | output | DW | Data register contents |

## Verification
The assertions assume that event inputs are single-cycle strobes and that `is_master` and `is_slave_sel` are never high together, because the engine cannot be master and addressed slave at once. The bench drives each strobe for exactly one cycle and changes the role levels only between steps, never with both role levels set. The stimulus places a status read in the same cycle as a byte-done strobe to exercise the priority rule. It also sends events with enables off and role levels low, and confirms at the status port that nothing changes.

// File: rtl/i2c_stat_unit.sv
module i2c_stat_unit #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_own_addr,
  input  logic          ev_gen_call,
  input  logic          ev_byte_done,
  input  logic          ev_stop,
  input  logic          ev_arb_lost,
  input  logic          ev_ack_smp,
  input  logic          ack_nack,
  input  logic          is_master,
  input  logic          is_slave_sel,
  input  logic          is_tx,
  input  logic          bus_busy,
  input  logic          ack_en,
  input  logic          gc_en,
  input  logic          stat_rd,
  output logic [7:0]    stat_q,
  output logic          irq,
  output logic          irq_stop,
  input  logic          dat_wr,
  input  logic [DW-1:0] dat_wdata,
  input  logic          shift_en,
  input  logic          shift_in,
  output logic          shift_out,
  output logic [DW-1:0] dat_q
);

  logic gc_f, stop_f, intr_f, kind_f, tx_f, bb_f, bl_f, nack_f, slv_f;
  logic [DW-1:0] dat_r;

  wire gc_hit   = ev_gen_call && gc_en && ack_en;
  wire stop_hit = ev_stop && is_slave_sel;
  wire ack_hit  = (ev_own_addr && ack_en) || gc_hit ||
                  (ev_byte_done && (is_master || is_slave_sel));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gc_f <= 1'b0; stop_f <= 1'b0; intr_f <= 1'b0; kind_f <= 1'b0;
      tx_f <= 1'b0; bb_f <= 1'b0; bl_f <= 1'b0; nack_f <= 1'b0; slv_f <= 1'b0;
    end else begin
      tx_f  <= is_tx;
      bb_f  <= bus_busy;
      slv_f <= is_slave_sel;
      if (ev_ack_smp) nack_f <= ack_nack;

      if (ack_hit || stop_hit) intr_f <= 1'b1;
      else if (stat_rd)        intr_f <= 1'b0;

      if (stop_hit)     kind_f <= 1'b1;
      else if (ack_hit) kind_f <= 1'b0;

      if (gc_hit)       gc_f <= 1'b1;
      else if (stat_rd) gc_f <= 1'b0;

      if (stop_hit)     stop_f <= 1'b1;
      else if (stat_rd) stop_f <= 1'b0;

      if (ev_arb_lost)  bl_f <= 1'b1;
      else if (stat_rd) bl_f <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        dat_r <= '0;
    else if (dat_wr)   dat_r <= dat_wdata;
    else if (shift_en) dat_r <= {dat_r[DW-2:0], shift_in};
  end

  assign stat_q    = {gc_f, stop_f, intr_f, tx_f, bb_f, bl_f, nack_f, slv_f};
  assign irq       = intr_f;
  assign irq_stop  = intr_f & kind_f;
  assign dat_q     = dat_r;
  assign shift_out = dat_r[DW-1];

  // R3
  own_addr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_own_addr && ack_en |=> irq);

  // R4
  gen_call_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_gen_call && gc_en && ack_en |=> stat_q[7] && irq);

  // R6
  stop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_slave_sel && !stat_q[6] |=> !stat_q[6]);

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !ev_own_addr && !ev_gen_call && !ev_byte_done && !ev_stop
    |=> !irq && !stat_q[7] && !stat_q[6]);

  // R9
  read_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && ev_byte_done && (is_master || is_slave_sel) |=> irq);

  // R10
  stop_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stop |-> irq && stat_q[6]);

  // R11
  shift_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en && !dat_wr |=> dat_q == {$past(dat_q[DW-2:0]), $past(shift_in)});

  // R7
  nack_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack_smp |=> stat_q[1] == $past(ack_nack));

endmodule

// File: tb/i2c_stat_unit_bench.sv
module i2c_stat_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_own_addr = 0, ev_gen_call = 0, ev_byte_done = 0, ev_stop = 0;
  logic ev_arb_lost = 0, ev_ack_smp = 0, ack_nack = 0;
  logic is_master = 0, is_slave_sel = 0, is_tx = 0, bus_busy = 0;
  logic ack_en = 0, gc_en = 0, stat_rd = 0;
  logic dat_wr = 0, shift_en = 0, shift_in = 0;
  logic [7:0] dat_wdata = 8'h00;
  logic [7:0] stat_q, dat_q;
  logic irq, irq_stop, shift_out;

  i2c_stat_unit #(.DW(8)) u_i2c_stat_unit (
    .clk(clk), .rst_n(rst_n),
    .ev_own_addr(ev_own_addr), .ev_gen_call(ev_gen_call),
    .ev_byte_done(ev_byte_done), .ev_stop(ev_stop),
    .ev_arb_lost(ev_arb_lost), .ev_ack_smp(ev_ack_smp), .ack_nack(ack_nack),
    .is_master(is_master), .is_slave_sel(is_slave_sel), .is_tx(is_tx),
    .bus_busy(bus_busy), .ack_en(ack_en), .gc_en(gc_en), .stat_rd(stat_rd),
    .stat_q(stat_q), .irq(irq), .irq_stop(irq_stop),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .shift_en(shift_en),
    .shift_in(shift_in), .shift_out(shift_out), .dat_q(dat_q)
  );

  always #2 clk = ~clk;

  typedef struct {
    int         due;
    logic [7:0] st;
    logic       irq;
    logic       irqs;
    logic [7:0] dat;
    string      req;
  } exp_t;

  exp_t sb[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (stat_q !== e.st || irq !== e.irq || irq_stop !== e.irqs ||
          dat_q !== e.dat || shift_out !== e.dat[7]) begin
        errors++;
        $display("FAIL %s: stat=%h irq=%b irq_stop=%b dat=%h so=%b expected stat=%h irq=%b irq_stop=%b dat=%h so=%b",
                 e.req, stat_q, irq, irq_stop, dat_q, shift_out,
                 e.st, e.irq, e.irqs, e.dat, e.dat[7]);
      end
    end
  end

  task automatic step(input logic [7:0] st, input logic ir, input logic irs,
                      input logic [7:0] dat, input string req);
    exp_t e;
    e.due = cyc + 1; e.st = st; e.irq = ir; e.irqs = irs; e.dat = dat; e.req = req;
    sb.push_back(e);
    @(negedge clk);
    ev_own_addr = 0; ev_gen_call = 0; ev_byte_done = 0; ev_stop = 0;
    ev_arb_lost = 0; ev_ack_smp = 0; stat_rd = 0; dat_wr = 0; shift_en = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    checks++;
    if (stat_q !== 8'h00 || irq !== 0 || irq_stop !== 0 || dat_q !== 8'h00) begin
      errors++;
      $display("FAIL R1: stat=%h irq=%b dat=%h expected 00 0 00", stat_q, irq, dat_q);
    end
    ack_en = 1; is_slave_sel = 1;
    ev_own_addr = 1;                       step(8'h21, 1, 0, 8'h00, "R3");
    stat_rd = 1;                           step(8'h01, 0, 0, 8'h00, "R8");
    ack_en = 0; ev_own_addr = 1;           step(8'h01, 0, 0, 8'h00, "R3");
    ack_en = 1; gc_en = 1; ev_gen_call = 1; step(8'hA1, 1, 0, 8'h00, "R4");
    stat_rd = 1;                           step(8'h01, 0, 0, 8'h00, "R8");
    gc_en = 0; ev_gen_call = 1;            step(8'h01, 0, 0, 8'h00, "R4");
    gc_en = 1; ack_en = 0; ev_gen_call = 1; step(8'h01, 0, 0, 8'h00, "R4");
    ack_en = 1; is_tx = 1;
    ev_byte_done = 1; ev_ack_smp = 1; ack_nack = 1; step(8'h33, 1, 0, 8'h00, "R5");
    stat_rd = 1; ev_byte_done = 1;         step(8'h33, 1, 0, 8'h00, "R9");
    stat_rd = 1;                           step(8'h13, 0, 0, 8'h00, "R8");
    ev_ack_smp = 1; ack_nack = 0;          step(8'h11, 0, 0, 8'h00, "R7");
    ev_stop = 1;                           step(8'h71, 1, 1, 8'h00, "R6");
    stat_rd = 1; is_slave_sel = 0; is_tx = 0; step(8'h00, 0, 0, 8'h00, "R10");
    ev_stop = 1;                           step(8'h00, 0, 0, 8'h00, "R6");
    ev_byte_done = 1;                      step(8'h00, 0, 0, 8'h00, "R5");
    is_master = 1; ev_arb_lost = 1; ev_byte_done = 1; step(8'h24, 1, 0, 8'h00, "R5");
    stat_rd = 1; bus_busy = 1;             step(8'h08, 0, 0, 8'h00, "R2");
    ev_byte_done = 1;                      step(8'h28, 1, 0, 8'h00, "R10");
    dat_wr = 1; dat_wdata = 8'hA5;         step(8'h28, 1, 0, 8'hA5, "R11");
    shift_en = 1; shift_in = 0;            step(8'h28, 1, 0, 8'h4A, "R11");
    shift_en = 1; shift_in = 1;            step(8'h28, 1, 0, 8'h95, "R11");
    shift_en = 1; dat_wr = 1; dat_wdata = 8'h3C; step(8'h28, 1, 0, 8'h3C, "R11");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule